// File: doc/BRIEF.md
# Per-Processor Timer Tick Skip Counter

This block lets each of four processors skip a programmed number of periodic timer ticks. All processors share one tick input. Each processor has a 24-bit down-counter with a sticky overflow flag above it. Every rising edge of the tick input lowers each counter by one. When a counter borrows past zero, its overflow flag sets and stays set. The counter keeps running after that, so software can read back how many ticks were missed since the borrow.

On every tick that leaves a processor's overflow flag set, the block sends that processor a one-cycle pulse. This pulse sets the processor's timer-interrupt flag, which lives elsewhere. The pulses repeat on every later tick until software rewrites the count, because a write clears the overflow flag.

The tick input may be asynchronous. It passes through a synchroniser and an edge detector inside the block. A presence mask stops counting and pulses for processors that are not fitted.

Top module: `tick_skip_counter`

## Requirements
- R1: After reset every counter and overflow flag reads as zero and no timer-set pulse is driven.
- R2: A write to a processor's register loads bits 23:0 of the write data into the count and clears the overflow flag (bit 24). Write data bits 31:24 are ignored.
- R3: The four processor registers sit at byte offsets 0x380, 0x3C0, 0x700 and 0x740, for processors 0 to 3. A read returns the count in bits 23:0, the overflow flag in bit 24 and zero above. A read at any other offset returns zero.
- R4: Each tick turns a present processor's 25-bit value v into ((v - 1) mod 2^25), with bit 24 kept high if it was already high.
- R5: Only a low-to-high transition of the tick input counts. Holding it high for many cycles gives one decrement, and its falling edge changes nothing.
- R6: A tick on a count of zero sets the overflow flag and leaves the count at 0xFFFFFF. Later ticks keep decrementing with the flag held.
- R7: Each tick that leaves a present processor's overflow flag set raises that processor's timer-set output for exactly one clock cycle. This repeats on every such tick until the register is rewritten.
- R8: A processor whose presence bit is low neither counts nor pulses, but its register can still be written and read.
- R9: When a write to a processor's register takes effect in the same cycle as a tick, the write wins. That processor loses the tick and gives no pulse, while the other processors count normally.
- R10: A count update and its timer-set pulse appear on the third rising clock edge after the tick input goes high: two synchroniser stages, then the counter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Shared periodic tick, may be asynchronous |
| cpuPresent | input | 4 | One presence bit per processor |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| timerSet | output | 4 | One-cycle timer-interrupt set pulse per processor |

## Verification
The bench builds the block with its default parameters: four processors, a 24-bit count and two synchroniser stages. Loading counts of zero to three brings the borrow, the sticky flag and the repeating pulses within a few ticks, without walking the full 2^24 range. Presence bits are toggled at random, and a write is aligned by cycle with a synchronised tick edge, so that absence and the write-over-tick priority are both exercised.

// File: rtl/tick_skip_pkg.sv
package tick_skip_pkg;
  localparam int TS_CPUS  = 4;
  localparam int TS_CNT_W = 24;

  // Strobes sent from control to datapath in one cycle
  typedef struct packed {
    logic                tickStep;
    logic [TS_CPUS-1:0]  wrSel;
  } skip_strobe_t;
endpackage

// File: rtl/tick_skip_ctrl.sv
module tick_skip_ctrl
  import tick_skip_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tickIn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  output skip_strobe_t        strobe,
  output logic [TS_CPUS-1:0]  rdSel
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], tickIn};
      prevQ <= syncQ[TOP];
    end
  end

  // Register byte offset for processor idx: two pairs, 0x40 apart
  function automatic logic [ADDR_W-1:0] slotOffset(input int idx);
    int v;
    v = (idx < 2) ? (12'h380 + 12'h040 * idx) : (12'h700 + 12'h040 * (idx - 2));
    return ADDR_W'(v);
  endfunction

  logic [TS_CPUS-1:0] hit;
  for (genvar g = 0; g < TS_CPUS; g++) begin : g_dec
    assign hit[g] = (regAddr == slotOffset(g));
  end

  assign rdSel           = hit;
  assign strobe.wrSel    = regWrEn ? hit : '0;
  assign strobe.tickStep = syncQ[TOP] & ~prevQ;

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.tickStep |=> !strobe.tickStep);
  // R2
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe.wrSel));
endmodule

// File: rtl/tick_skip_dp.sv
module tick_skip_dp
  import tick_skip_pkg::*;
#(
  parameter int CNT_W  = TS_CNT_W,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  skip_strobe_t        strobe,
  input  logic [TS_CPUS-1:0]  rdSel,
  input  logic [TS_CPUS-1:0]  cpuPresent,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [TS_CPUS-1:0]  timerSet
);
  localparam int VAL_W = CNT_W + 1;

  logic [CNT_W-1:0] cntQ  [TS_CPUS];
  logic             ovfQ  [TS_CPUS];
  logic [CNT_W-1:0] loadVal;

  assign loadVal = regWrData[CNT_W-1:0];

  for (genvar g = 0; g < TS_CPUS; g++) begin : g_cpu
    logic [VAL_W-1:0] decVal;
    logic             nextOvf;

    assign decVal  = {ovfQ[g], cntQ[g]} - {{CNT_W{1'b0}}, 1'b1};
    assign nextOvf = decVal[CNT_W] | ovfQ[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cntQ[g]     <= '0;
        ovfQ[g]     <= 1'b0;
        timerSet[g] <= 1'b0;
      end else begin
        timerSet[g] <= 1'b0;
        if (strobe.wrSel[g]) begin
          cntQ[g] <= loadVal;
          ovfQ[g] <= 1'b0;
        end else if (strobe.tickStep && cpuPresent[g]) begin
          cntQ[g]     <= decVal[CNT_W-1:0];
          ovfQ[g]     <= nextOvf;
          timerSet[g] <= nextOvf;
        end
      end
    end

    // R6
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovfQ[g] && !strobe.wrSel[g]) |=> ovfQ[g]);
    // R2
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.wrSel[g] |=> (!ovfQ[g] && cntQ[g] == $past(loadVal)));
    // R7
    pulse_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timerSet[g] |-> ovfQ[g]);
    // R8
    absent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpuPresent[g] && !strobe.wrSel[g]) |=> ($stable(cntQ[g]) && !timerSet[g]));
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < TS_CPUS; i++) begin
      if (rdSel[i]) regRdData = DATA_W'({ovfQ[i], cntQ[i]});
    end
  end
endmodule

// File: rtl/tick_skip_counter.sv
module tick_skip_counter
  import tick_skip_pkg::*;
#(
  parameter int CNT_W       = TS_CNT_W,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tickIn,
  input  logic [TS_CPUS-1:0]  cpuPresent,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [TS_CPUS-1:0]  timerSet
);
  skip_strobe_t        strobe;
  logic [TS_CPUS-1:0]  rdSel;

  tick_skip_ctrl #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tickIn(tickIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .strobe(strobe), .rdSel(rdSel)
  );

  tick_skip_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdSel(rdSel),
    .cpuPresent(cpuPresent), .regWrData(regWrData),
    .regRdData(regRdData), .timerSet(timerSet)
  );
endmodule

// File: tb/tick_skip_counter_tb.sv
module tick_skip_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickIn = 1'b0;
  logic [3:0]  cpuPresent = 4'hF;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  timerSet;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [24:0] model [4];
  logic [11:0] offs  [4];

  always #4 clk = ~clk;

  tick_skip_counter u_dut (
    .clk(clk), .rst_n(rst_n), .tickIn(tickIn), .cpuPresent(cpuPresent),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .timerSet(timerSet)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  function automatic logic [24:0] stepVal(input logic [24:0] v);
    return ((v - 25'd1) & 25'h1FFFFFF) | (v & 25'h1000000);
  endfunction

  task automatic readCheck(input string req, input int c);
    @(negedge clk);
    regAddr = offs[c];
    #1;
    check(req, regRdData, {7'b0, model[c]});
  endtask

  task automatic readAll(input string req);
    for (int c = 0; c < 4; c++) readCheck(req, c);
  endtask

  task automatic writeReg(input int c, input logic [31:0] d);
    @(negedge clk);
    regAddr = offs[c]; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    model[c] = {1'b0, d[23:0]};
  endtask

  // R10: raise at negedge, update visible after the third posedge
  task automatic doTick(input string req);
    logic [3:0] expPulse;
    @(negedge clk);
    tickIn = 1'b1;
    expPulse = '0;
    for (int c = 0; c < 4; c++) begin
      if (cpuPresent[c]) begin
        model[c] = stepVal(model[c]);
        expPulse[c] = model[c][24];
      end
    end
    @(posedge clk); @(posedge clk);
    #1 check({req, " R10 early"}, {28'b0, timerSet}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check({req, " R7 pulse"}, {28'b0, timerSet}, {28'b0, expPulse});
    @(negedge clk);
    check({req, " R7 one-cycle"}, {28'b0, timerSet}, 32'h0);
    tickIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    offs[0] = 12'h380; offs[1] = 12'h3C0; offs[2] = 12'h700; offs[3] = 12'h740;
    for (int c = 0; c < 4; c++) model[c] = '0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    readAll("R1 reset");
    check("R1 timerSet", {28'b0, timerSet}, 32'h0);

    // R2 load with upper bits ignored, R3 layout and unmapped read
    writeReg(0, 32'hFF123456);
    readCheck("R2 load", 0);
    check("R2 mask", regRdData, 32'h00123456);
    @(negedge clk); regAddr = 12'h400; #1;
    check("R3 unmapped", regRdData, 32'h0);
    writeReg(1, 32'h2); writeReg(2, 32'h0); writeReg(3, 32'h1);
    readAll("R3 layout");

    // R4 / R6 / R7 borrow sequence
    doTick("R4 t1");
    readAll("R4 after t1");
    readCheck("R6 wrap", 2);
    check("R6 value", regRdData, 32'h01FFFFFF);
    doTick("R7 t2");
    doTick("R7 t3");
    readAll("R6 counting on");

    // R2 rewrite clears overflow, stops pulses
    writeReg(2, 32'h5);
    readCheck("R2 clear", 2);
    doTick("R7 after rewrite");

    // R5 hold high long, then fall
    writeReg(0, 32'h10);
    @(negedge clk); tickIn = 1'b1;
    for (int c = 0; c < 4; c++) if (cpuPresent[c]) model[c] = stepVal(model[c]);
    repeat (12) @(negedge clk);
    readAll("R5 level held");
    @(negedge clk); tickIn = 1'b0;
    repeat (6) @(negedge clk);
    readAll("R5 fall ignored");

    // R8 absent processor
    writeReg(1, 32'h0);
    cpuPresent = 4'b1101;
    doTick("R8 absent");
    readAll("R8 held");
    cpuPresent = 4'hF;

    // R9 write and tick in the same cycle
    begin
      logic [3:0] expPulse;
      writeReg(3, 32'h0);
      @(negedge clk); tickIn = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      regAddr = offs[3]; regWrData = 32'h77; regWrEn = 1'b1;
      @(posedge clk);
      @(negedge clk);
      regWrEn = 1'b0;
      expPulse = '0;
      for (int c = 0; c < 3; c++) begin
        model[c] = stepVal(model[c]);
        expPulse[c] = model[c][24];
      end
      model[3] = 25'h77;
      check("R9 pulse", {28'b0, timerSet}, {28'b0, expPulse});
      tickIn = 1'b0;
      repeat (3) @(negedge clk);
      readAll("R9 write wins");
    end

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        int c;
        c = $urandom_range(0, 3);
        writeReg(c, ($urandom_range(0, 3) == 0) ? $urandom() : 32'($urandom_range(0, 3)));
      end else if (op < 8) begin
        doTick("R4 random");
      end else begin
        cpuPresent = 4'($urandom_range(0, 15));
      end
      readCheck("R4 random read", $urandom_range(0, 3));
    end
    cpuPresent = 4'hF;
    readAll("R4 final");

    summary();
  end
endmodule